// File: doc/BRIEF.md
# Pseudo-Static RAM Strobe Sequencer

This block sits between a synchronous on-chip requester and an external 16-bit pseudo-static RAM with two byte lanes. A requester hands over one word-sized read or write at a time on a valid/ready handshake. The block replays it as an asynchronous strobe sequence on the memory pins: address, chip select, read strobe, write strobe, per-lane byte strobes, and a data bus split into an outgoing value, a drive enable and an incoming value. A read returns its word with a one-clock valid pulse.

Every timing minimum of the memory is a parameter in nanoseconds. Each one is turned into a clock count by ceiling division with the clock period parameter, and never falls below one clock. Reads are always started by chip select: the address is placed one clock before chip select falls. Every access ends with a deselect gap during which all strobes are high.

Top module: `psram_ctrl`

## Requirements
- R1: While reset is low, and right after it, `req_ready` is 1, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, both `mem_be_n` bits are 1, `mem_dq_oe` is 0 and `rsp_valid` is 0.
- R2: A request is taken on the clock edge where `req_valid` and `req_ready` are both 1. On that edge `mem_addr` takes the request address and all strobes stay high for exactly one clock. Chip select falls on the next edge while the address is unchanged.
- R3: A read holds `mem_ce_n`, `mem_oe_n` and both `mem_be_n` bits low for `C_RD` clocks. `C_RD` is the largest of the clock counts for cycle time, select-to-data and read-strobe-to-data: 4 clocks at 20 ns with 70/70/35 ns. The word on `mem_dq_in` is sampled at the edge that ends the last of those clocks. In the clock that follows, `rsp_valid` is 1 for exactly one clock with that word on `rsp_rdata`.
- R4: A write holds `mem_ce_n` and `mem_we_n` low for `C_WR` clocks. `C_WR` is the largest of the counts for write-strobe width, select-to-write-end, address-to-write-end, bus-release plus data-setup, and cycle time. `mem_oe_n` stays high. `mem_be_n[i]` is low exactly when `req_mask[i]` is 1: bit 0 is the lane of data bits 7:0 and bit 1 the lane of bits 15:8.
- R5: During a write, `mem_dq_oe` stays 0 for the first `C_REL` clocks (the bus-release count), then is 1 until the edge where `mem_we_n` rises, which clears it. While it is 1, `mem_dq_out` carries the request's write data. `mem_dq_oe` is never 1 while `mem_oe_n` is low or `mem_we_n` is high.
- R6: A write with mask 0 keeps both `mem_be_n` bits high and still runs with normal timing. It leaves the memory contents unchanged, as a later read shows.
- R7: After each access, `mem_ce_n`, `mem_oe_n`, `mem_we_n` and both `mem_be_n` bits are high for `C_GAP` clocks (the deselect count) before the block can accept again.
- R8: `req_ready` is 0 from the accepting edge until the deselect gap has ended. A request presented while it is 0 is ignored.
- R9: `rsp_valid` is never 1 as a result of a write.
- R10: Chip select is never held low for more than the selection limit (40 µs, as a clock count). Parameter sets whose longest access would exceed it are rejected at elaboration.
- R11: Each nanosecond minimum becomes ceil(ns / clock period) clocks, with a floor of one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte lanes to write, bit 0 = low byte |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | DATA_W/8 | Byte strobes, active low |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
A phase or counter out of step shows up within one clock as a strobe that rises or falls one edge early or late. It can also show as a read word sampled before its access time has passed, which a slow memory model turns into a wrong `rsp_rdata`. A wrong lane decode or a bus driven too early shows on `mem_be_n` or `mem_dq_oe` in the first write clock that it affects. It also shows later as a read-back word that differs in one byte. A busy flag that clears too soon shows as `req_ready` rising inside the gap, and as a second access whose chip select falls without the full deselect time.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_READ  = 3'd2,
      PH_WRITE = 3'd3,
      PH_GAP   = 3'd4
   } phase_t;

   // nanoseconds -> clocks, rounded up, never below one clock
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_req_hold.sv
module psram_req_hold #(
   parameter int unsigned AW    = 22,
   parameter int unsigned DW    = 16,
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             in_write,
   input  logic [AW-1:0]    in_addr,
   input  logic [DW-1:0]    in_wdata,
   input  logic [LANES-1:0] in_mask,
   output logic             out_write,
   output logic [AW-1:0]    out_addr,
   output logic [DW-1:0]    out_wdata,
   output logic [LANES-1:0] out_mask
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_write <= 1'b0;
         out_addr  <= '0;
         out_wdata <= '0;
         out_mask  <= '0;
      end else if (load) begin
         out_write <= in_write;
         out_addr  <= in_addr;
         out_wdata <= in_wdata;
         out_mask  <= in_mask;
      end
   end

endmodule

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (cnt != '1)
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/psram_lane_enables.sv
module psram_lane_enables #(
   parameter int unsigned LANES = 2
) (
   input  logic             active,
   input  logic             is_read,
   input  logic [LANES-1:0] mask,
   output logic [LANES-1:0] be_n_nxt
);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_n_nxt[i] = !(active && (is_read || mask[i]));
   end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
   import psram_ctrl_pkg::*;
#(
   parameter int unsigned ADDR_W         = 22,
   parameter int unsigned DATA_W         = 16,
   parameter int unsigned CLK_NS         = 20,
   parameter int unsigned T_CYCLE_NS     = 70,
   parameter int unsigned T_DESEL_NS     = 15,
   parameter int unsigned T_CE_DATA_NS   = 70,
   parameter int unsigned T_OE_DATA_NS   = 35,
   parameter int unsigned T_WE_PULSE_NS  = 50,
   parameter int unsigned T_CE_WEND_NS   = 60,
   parameter int unsigned T_ADDR_WEND_NS = 60,
   parameter int unsigned T_DATA_WEND_NS = 25,
   parameter int unsigned T_BUS_REL_NS   = 25,
   parameter int unsigned T_SEL_MAX_NS   = 40000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   output logic                  req_ready,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [DATA_W-1:0]     req_wdata,
   input  logic [DATA_W/8-1:0]   req_mask,
   output logic                  rsp_valid,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic                  mem_ce_n,
   output logic                  mem_oe_n,
   output logic                  mem_we_n,
   output logic [DATA_W/8-1:0]   mem_be_n,
   output logic [DATA_W-1:0]     mem_dq_out,
   output logic                  mem_dq_oe,
   input  logic [DATA_W-1:0]     mem_dq_in
);

   localparam int unsigned LANES     = DATA_W / 8;
   localparam int unsigned C_CYCLE   = ns2cyc(T_CYCLE_NS, CLK_NS);
   localparam int unsigned C_GAP     = ns2cyc(T_DESEL_NS, CLK_NS);
   localparam int unsigned C_RD      = umax(umax(ns2cyc(T_CE_DATA_NS, CLK_NS),
                                                 ns2cyc(T_OE_DATA_NS, CLK_NS)), C_CYCLE);
   localparam int unsigned C_PWE     = ns2cyc(T_WE_PULSE_NS, CLK_NS);
   localparam int unsigned C_REL     = ns2cyc(T_BUS_REL_NS, CLK_NS);
   localparam int unsigned C_SD      = ns2cyc(T_DATA_WEND_NS, CLK_NS);
   localparam int unsigned C_WR      = umax(umax(umax(C_PWE, ns2cyc(T_CE_WEND_NS, CLK_NS)),
                                                 umax(ns2cyc(T_ADDR_WEND_NS, CLK_NS), C_REL + C_SD)),
                                            C_CYCLE);
   localparam int unsigned C_SEL_MAX = T_SEL_MAX_NS / CLK_NS;
   localparam int unsigned C_TOP     = umax(umax(C_RD, C_WR), C_GAP);
   localparam int unsigned CNT_W     = $clog2(C_TOP + 1);

   // elaboration-time parameter checks
   if (CLK_NS == 0) begin : g_bad_clk
      $error("psram_ctrl: CLK_NS must be non-zero");
   end
   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("psram_ctrl: DATA_W must be a non-zero multiple of 8");
   end
   if (C_RD > C_SEL_MAX || C_WR > C_SEL_MAX) begin : g_bad_sel_R10
      $error("psram_ctrl: longest access exceeds the selection limit");
   end

   phase_t               ph_q, ph_d;
   logic [CNT_W-1:0]     cnt;
   logic [CNT_W:0]       cnt_ahead;
   logic                 accept, restart;
   logic                 hold_write;
   logic [LANES-1:0]     hold_mask;
   logic [LANES-1:0]     be_n_d;
   logic                 dq_oe_d;

   assign req_ready = (ph_q == PH_IDLE);
   assign accept    = req_valid && req_ready;

   psram_req_hold #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES)) i_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .in_write  (req_write),
      .in_addr   (req_addr),
      .in_wdata  (req_wdata),
      .in_mask   (req_mask),
      .out_write (hold_write),
      .out_addr  (mem_addr),
      .out_wdata (mem_dq_out),
      .out_mask  (hold_mask)
   );

   psram_phase_timer #(.W(CNT_W)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .cnt     (cnt)
   );

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:  if (accept) ph_d = PH_SETUP;
         PH_SETUP: ph_d = hold_write ? PH_WRITE : PH_READ;
         PH_READ:  if (cnt == CNT_W'(C_RD - 1))  ph_d = PH_GAP;
         PH_WRITE: if (cnt == CNT_W'(C_WR - 1))  ph_d = PH_GAP;
         PH_GAP:   if (cnt == CNT_W'(C_GAP - 1)) ph_d = PH_IDLE;
         default:  ph_d = PH_IDLE;
      endcase
   end

   assign restart   = (ph_d != ph_q);
   assign cnt_ahead = restart ? '0 : ({1'b0, cnt} + 1'b1);
   assign dq_oe_d   = (ph_d == PH_WRITE) && (ph_q == PH_WRITE) &&
                      (cnt_ahead >= (CNT_W + 1)'(C_REL));

   psram_lane_enables #(.LANES(LANES)) i_lanes (
      .active   ((ph_d == PH_READ) || (ph_d == PH_WRITE)),
      .is_read  (ph_d == PH_READ),
      .mask     (hold_mask),
      .be_n_nxt (be_n_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         mem_ce_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_be_n  <= '1;
         mem_dq_oe <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         ph_q      <= ph_d;
         mem_ce_n  <= !((ph_d == PH_READ) || (ph_d == PH_WRITE));
         mem_oe_n  <= !(ph_d == PH_READ);
         mem_we_n  <= !(ph_d == PH_WRITE);
         mem_be_n  <= be_n_d;
         mem_dq_oe <= dq_oe_d;
         rsp_valid <= (ph_q == PH_READ) && (ph_d == PH_GAP);
         if ((ph_q == PH_READ) && (ph_d == PH_GAP))
            rsp_rdata <= mem_dq_in;
      end
   end

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
   parameter int unsigned AW        = 22,
   parameter int unsigned LANES     = 2,
   parameter int unsigned C_GAP     = 1,
   parameter int unsigned C_PWE     = 3,
   parameter int unsigned C_REL     = 2,
   parameter int unsigned C_SEL_MAX = 2000
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic [AW-1:0]    mem_addr,
   input logic             mem_ce_n,
   input logic             mem_oe_n,
   input logic             mem_we_n,
   input logic [LANES-1:0] mem_be_n,
   input logic             mem_dq_oe
);

   int unsigned ce_lo_run, ce_hi_run, we_lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_lo_run <= 0;
         ce_hi_run <= C_GAP;
         we_lo_run <= 0;
      end else begin
         ce_lo_run <= mem_ce_n ? 0 : ((ce_lo_run <= C_SEL_MAX) ? ce_lo_run + 1 : ce_lo_run);
         ce_hi_run <= !mem_ce_n ? 0 : ((ce_hi_run <= C_GAP) ? ce_hi_run + 1 : ce_hi_run);
         we_lo_run <= mem_we_n ? 0 : ((we_lo_run <= C_SEL_MAX) ? we_lo_run + 1 : we_lo_run);
      end
   end

   assert_addr_settled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> $stable(mem_addr));

   assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (we_lo_run >= C_PWE));

   assert_bus_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && mem_oe_n));

   assert_bus_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_dq_oe) |-> (we_lo_run >= C_REL));

   assert_desel_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (ce_hi_run >= C_GAP));

   assert_lanes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce_n |-> (&mem_be_n));

   assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> !req_ready);

   assert_rsp_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!mem_oe_n));

   assert_sel_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce_n |-> (ce_lo_run < C_SEL_MAX));

endmodule

bind psram_ctrl psram_ctrl_chk #(
   .AW        (ADDR_W),
   .LANES     (LANES),
   .C_GAP     (C_GAP),
   .C_PWE     (C_PWE),
   .C_REL     (C_REL),
   .C_SEL_MAX (C_SEL_MAX)
) i_psram_ctrl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_be_n  (mem_be_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_psram_ctrl.sv
module test_psram_ctrl;

   localparam int AW = 22;
   localparam int DW = 16;
   localparam int CLKP = 20;
   localparam int NS_CYCLE = 70, NS_DESEL = 30, NS_CE = 70, NS_OE = 35;
   localparam int NS_PWE = 50, NS_SCE = 60, NS_AW = 60, NS_SD = 25, NS_REL = 0;
   localparam int NS_SELMAX = 40000;

   // R11: bench's own conversion, counted upward
   function automatic int to_clk(input int ns);
      int n;
      n = 0;
      while (n * CLKP < ns) n++;
      if (n == 0) n = 1;
      return n;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   int e_rd, e_wr, e_rel, e_gap, e_selmax;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0] req_mask = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [DW-1:0] rsp_rdata, mem_dq_out, mem_dq_in;
   logic [AW-1:0] mem_addr;
   logic [1:0] mem_be_n;

   always #10 clk = ~clk;

   psram_ctrl #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLKP), .T_CYCLE_NS(NS_CYCLE),
      .T_DESEL_NS(NS_DESEL), .T_CE_DATA_NS(NS_CE), .T_OE_DATA_NS(NS_OE),
      .T_WE_PULSE_NS(NS_PWE), .T_CE_WEND_NS(NS_SCE), .T_ADDR_WEND_NS(NS_AW),
      .T_DATA_WEND_NS(NS_SD), .T_BUS_REL_NS(NS_REL), .T_SEL_MAX_NS(NS_SELMAX)
   ) i_psram_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // memory device model
   logic [DW-1:0] dev [16];
   logic [DW-1:0] shadow [16];
   logic wlow = 0;
   logic [1:0] lbe;
   logic [DW-1:0] ldat;
   logic [3:0] ladr;

   assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ? dev[mem_addr[3:0]] : 16'hBEEF;

   always @(posedge clk) begin
      if (!mem_we_n && !mem_ce_n) begin
         wlow <= 1;
         lbe  <= mem_be_n;
         ladr <= mem_addr[3:0];
         if (mem_dq_oe) ldat <= mem_dq_out;
      end else if (wlow) begin
         wlow <= 0;
         if (!lbe[0]) dev[ladr][7:0]  <= ldat[7:0];
         if (!lbe[1]) dev[ladr][15:8] <= ldat[15:8];
      end
   end

   // expected per-clock port values
   typedef struct {
      int kind; // 0 setup,1 read,2 write,3 gap after read,4 idle,5 gap after write
      bit ready, ce_n, oe_n, we_n, dq_oe, rsp;
      bit [1:0] be_n;
      bit chk_addr;
      bit [AW-1:0] addr;
      bit [DW-1:0] rd, wd;
   } exp_t;

   exp_t sched[$];
   int checks = 0, errs = 0;
   bit took;
   int cyc = 0, ce_run = 0, ce_max = 0;

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic string tg(input int k);
      case (k)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R7";
         5: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic compare();
      exp_t e;
      if (sched.size() > 0) e = sched.pop_front();
      else begin
         e = '{kind:4, ready:1, ce_n:1, oe_n:1, we_n:1, dq_oe:0, rsp:0, be_n:2'b11,
               chk_addr:0, addr:'0, rd:'0, wd:'0};
      end
      chk("R8", "req_ready", req_ready, e.ready);
      chk(e.kind == 1 ? "R3 R11" : (e.kind == 2 ? "R4 R11" : tg(e.kind)), "mem_ce_n", mem_ce_n, e.ce_n);
      chk(e.kind == 1 ? "R3" : tg(e.kind), "mem_oe_n", mem_oe_n, e.oe_n);
      chk(e.kind == 2 ? "R4" : tg(e.kind), "mem_we_n", mem_we_n, e.we_n);
      chk(e.kind == 2 ? "R4 R6" : tg(e.kind), "mem_be_n", mem_be_n, e.be_n);
      chk("R5 R11", "mem_dq_oe", mem_dq_oe, e.dq_oe);
      chk((e.kind == 2 || e.kind == 5) ? "R9" : "R3", "rsp_valid", rsp_valid, e.rsp);
      if (e.chk_addr) chk("R2", "mem_addr", mem_addr, e.addr);
      if (e.rsp) chk("R3", "rsp_rdata", rsp_rdata, e.rd);
      if (e.dq_oe) chk("R5", "mem_dq_out", mem_dq_out, e.wd);
   endtask

   task automatic push_access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
      exp_t e;
      e = '{kind:0, ready:0, ce_n:1, oe_n:1, we_n:1, dq_oe:0, rsp:0, be_n:2'b11,
            chk_addr:1, addr:a, rd:'0, wd:d};
      sched.push_back(e);
      if (!w) begin
         for (int s = 1; s <= e_rd; s++) begin
            e.kind = 1; e.ce_n = 0; e.oe_n = 0; e.be_n = 2'b00;
            sched.push_back(e);
         end
         for (int g = 1; g <= e_gap; g++) begin
            e.kind = 3; e.ce_n = 1; e.oe_n = 1; e.be_n = 2'b11;
            e.rsp = (g == 1); e.rd = shadow[a[3:0]];
            sched.push_back(e);
         end
      end else begin
         for (int s = 1; s <= e_wr; s++) begin
            e.kind = 2; e.ce_n = 0; e.we_n = 0; e.be_n = ~m;
            e.dq_oe = (s >= e_rel + 1);
            sched.push_back(e);
         end
         for (int g = 1; g <= e_gap; g++) begin
            e.kind = 5; e.ce_n = 1; e.we_n = 1; e.be_n = 2'b11; e.dq_oe = 0;
            sched.push_back(e);
         end
         if (m[0]) shadow[a[3:0]][7:0]  = d[7:0];
         if (m[1]) shadow[a[3:0]][15:8] = d[15:8];
      end
   endtask

   task automatic tick(input bit v, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
      bit rdy;
      @(negedge clk);
      compare();
      rdy = req_ready;
      req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
      took = v && rdy;
      if (took) push_access(w, a, d, m);
   endtask

   // keeps valid high until taken; busy cycles present the same request (R8)
   task automatic do_req(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] m);
      do tick(1, w, a, d, m); while (!took);
   endtask

   task automatic drain();
      while (sched.size() > 0) tick(0, 0, '0, '0, 2'b00);
      tick(0, 0, '0, '0, 2'b00);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (!mem_ce_n) ce_run++; else ce_run = 0;
      if (ce_run > ce_max) ce_max = ce_run;
      if (cyc > 20000) begin
         checks++; errs++;
         $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      e_rd     = mx(mx(to_clk(NS_CE), to_clk(NS_OE)), to_clk(NS_CYCLE));
      e_rel    = to_clk(NS_REL);
      e_wr     = mx(mx(mx(to_clk(NS_PWE), to_clk(NS_SCE)), mx(to_clk(NS_AW), e_rel + to_clk(NS_SD))),
                    to_clk(NS_CYCLE));
      e_gap    = to_clk(NS_DESEL);
      e_selmax = NS_SELMAX / CLKP;
      for (int i = 0; i < 16; i++) begin
         dev[i]    = 16'(i * 16'h1111) ^ 16'h0F0F;
         shadow[i] = 16'(i * 16'h1111) ^ 16'h0F0F;
      end

      // R1: reset values
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1", "req_ready", req_ready, 1'b1);
         chk("R1", "strobes ce/oe/we", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
         chk("R1", "mem_be_n", mem_be_n, 2'b11);
         chk("R1", "dq_oe/rsp_valid", {mem_dq_oe, rsp_valid}, 2'b00);
      end
      rst_n = 1;
      tick(0, 0, '0, '0, 2'b00);

      do_req(0, 22'd3, '0, 2'b00);               // R3 plain read
      drain();
      do_req(1, 22'd3, 16'hA5C3, 2'b11);         // R4 R5 full write
      do_req(0, 22'd3, '0, 2'b00);               // back-to-back read-back, R7 R8
      drain();
      do_req(1, 22'd5, 16'h1234, 2'b01);         // lower lane only
      do_req(1, 22'd5, 16'hABCD, 2'b10);         // upper lane only
      do_req(0, 22'd5, '0, 2'b00);
      drain();
      do_req(1, 22'd3, 16'hFFFF, 2'b00);         // R6 empty mask
      do_req(0, 22'd3, '0, 2'b00);
      drain();
      for (int i = 8; i < 12; i++) begin
         do_req(1, 22'(i) | 22'h2A0000, 16'(i * 16'h0707 + 16'h0101), 2'(i));
      end
      for (int i = 8; i < 12; i++) begin
         do_req(0, 22'(i) | 22'h2A0000, '0, 2'b00);
      end
      drain();
      repeat (3) tick(0, 0, '0, '0, 2'b00);

      chk("R10", "longest select run within limit", (ce_max <= e_selmax) && (ce_max > 0), 1'b1);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule